// File: doc/BRIEF.md
# Dual-strobe up/down counter

This block is a binary counter that lives entirely in one system-clock domain. It has two count strobes instead of a direction bit. A rising edge on the up strobe adds one, but only while the down strobe rests high. A rising edge on the down strobe subtracts one, but only while the up strobe rests high. Both strobes are treated as slow level signals: each passes through a synchroniser, and the counter acts on the sampled transition.

A clear input and a parallel-load input override counting. Both reach the count output in the same cycle they are applied, and the register keeps their effect once they are released.

Two active-low terminal outputs copy the matching strobe when the count sits at a limit. The carry output follows the up strobe at the all-ones count. The borrow output follows the down strobe at zero. Wiring the carry to the next stage's up strobe and the borrow to its down strobe builds a wider counter from identical stages.

Top module: `dstrobe_counter`

## Requirements
- R1: A low-to-high transition of `up_stb` while `dn_stb` is high raises `q` by one.
- R2: A low-to-high transition of `dn_stb` while `up_stb` is high lowers `q` by one.
- R3: Counting wraps from all ones to 0 going up, and from 0 to all ones going down.
- R4: While `clr` is high, `q` is 0 in that same cycle and stays 0, whatever `load_n`, `din` and the strobes do. After release, `q` remains 0.
- R5: While `load_n` is low and `clr` is low, `q` equals `din` in that same cycle, whatever the strobes do. After release, `q` keeps the loaded value.
- R6: `tcu_n` is low exactly when `q` is all ones and the synchronised `up_stb` is low. Otherwise it is high.
- R7: `tcd_n` is low exactly when `q` is 0 and the synchronised `dn_stb` is low. Otherwise it is high.
- R8: A transition of one strobe while the other strobe is low does not change `q`.
- R9: A strobe held low through a clear or a load is counted on its first rise after release.
- R10: With two synchroniser stages, a strobe rise applied before clock edge k changes `q` after edge k+2, and not earlier.
- R11: Two stages chained (carry to up strobe, borrow to down strobe) form an 8-bit counter that wraps correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| up_stb | input | 1 | Up count strobe, counts on its rising edge |
| dn_stb | input | 1 | Down count strobe, counts on its rising edge |
| clr | input | 1 | Clear, active high, highest priority |
| load_n | input | 1 | Parallel load, active low |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Count value |
| tcu_n | output | 1 | Carry strobe, active low, follows up strobe at all ones |
| tcd_n | output | 1 | Borrow strobe, active low, follows down strobe at zero |

## Verification
Several properties are checked on every clock by the assertions:
- the clear and load effects on the stored count;
- the single-step increment and decrement;
- the wrap at the top;
- holding when no qualified edge arrives;
- the conditions under which each terminal output may be low.

The bench scenarios are needed for behaviour that spans many cycles:
- the exact two-cycle synchroniser latency;
- recovery of a strobe held low across clear or load;
- rejecting an edge while the other strobe is low;
- carry and borrow rippling through a two-stage chain into a correct 8-bit count.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   typedef enum logic [2:0] {
      ACT_HOLD,
      ACT_CLEAR,
      ACT_LOAD,
      ACT_INC,
      ACT_DEC
   } dsc_act_e;
endpackage

// File: rtl/dsc_strobe_sync.sv
module dsc_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   output logic lvl,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dsc_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= 1'b1;
         end else begin
            if (i == 0) chain[i] <= stb;
            else        chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
   import dsc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   input  logic             up_go,
   input  logic             dn_go,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   logic [WIDTH-1:0] cnt_r;
   logic [WIDTH-1:0] cnt_nx;
   dsc_act_e         act;

   always_comb begin
      if (clr)         act = ACT_CLEAR;
      else if (!load_n) act = ACT_LOAD;
      else if (up_go)  act = ACT_INC;
      else if (dn_go)  act = ACT_DEC;
      else             act = ACT_HOLD;
   end

   always_comb begin
      case (act)
         ACT_CLEAR: cnt_nx = '0;
         ACT_LOAD:  cnt_nx = din;
         ACT_INC:   cnt_nx = cnt_r + 1'b1;
         ACT_DEC:   cnt_nx = cnt_r - 1'b1;
         default:   cnt_nx = cnt_r;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_r <= '0;
      else        cnt_r <= cnt_nx;
   end

   assign q = clr ? '0 : (!load_n ? din : cnt_r);

   // R4
   clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_r == '0);
   // R5
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_n) |=> cnt_r == $past(din));
   // R1
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && up_go) |=> cnt_r == WIDTH'($past(cnt_r) + 1'b1));
   // R2
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && !up_go && dn_go) |=> cnt_r == WIDTH'($past(cnt_r) - 1'b1));
   // R3
   top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && up_go && cnt_r == TOP) |=> cnt_r == '0);
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && !up_go && !dn_go) |=> $stable(cnt_r));
endmodule

// File: rtl/dsc_terminal.sv
module dsc_terminal #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] q,
   input  logic             up_lvl,
   input  logic             dn_lvl,
   output logic             tcu_n,
   output logic             tcd_n
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   assign tcu_n = ~((q == TOP) & ~up_lvl);
   assign tcd_n = ~((q == '0)  & ~dn_lvl);
endmodule

// File: rtl/dstrobe_counter.sv
module dstrobe_counter #(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_stb,
   input  logic             dn_stb,
   input  logic             clr,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             tcu_n,
   output logic             tcd_n
);
   if (WIDTH < 1) begin : g_bad_width
      $error("dstrobe_counter: WIDTH must be at least 1");
   end

   localparam int NSTB = 2;

   logic [NSTB-1:0] stb_in;
   logic [NSTB-1:0] lvl;
   logic [NSTB-1:0] rise;
   logic            up_go;
   logic            dn_go;

   assign stb_in = {dn_stb, up_stb};

   for (genvar s = 0; s < NSTB; s++) begin : g_sync
      dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .stb  (stb_in[s]),
         .lvl  (lvl[s]),
         .rise (rise[s])
      );
   end

   // an edge only counts while the opposite strobe rests high
   assign up_go = rise[0] & lvl[1];
   assign dn_go = rise[1] & lvl[0];

   dsc_count_core #(.WIDTH(WIDTH)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .load_n(load_n),
      .din   (din),
      .up_go (up_go),
      .dn_go (dn_go),
      .q     (q)
   );

   dsc_terminal #(.WIDTH(WIDTH)) u_term (
      .q     (q),
      .up_lvl(lvl[0]),
      .dn_lvl(lvl[1]),
      .tcu_n (tcu_n),
      .tcd_n (tcd_n)
   );

   // R6
   carry_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tcu_n |-> (q == {WIDTH{1'b1}}) && !lvl[0]);
   // R7
   borrow_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tcd_n |-> (q == '0) && !lvl[1]);
   // R8
   both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl[0] && !lvl[1]) |-> !up_go && !dn_go);
endmodule

// File: tb/dstrobe_counter_bench.sv
`timescale 1ns/1ps
module dstrobe_counter_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       up0 = 1'b1, dn0 = 1'b1;
   logic       clr = 1'b0, load_n = 1'b1;
   logic [3:0] din0 = '0, din1 = '0;
   logic [3:0] q0, q1;
   logic       tcu0, tcd0, tcu1, tcd1;

   int errors = 0;
   int checks = 0;
   int ref8   = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dstrobe_counter u_dstrobe_counter (
      .clk(clk), .rst_n(rst_n), .up_stb(up0), .dn_stb(dn0),
      .clr(clr), .load_n(load_n), .din(din0),
      .q(q0), .tcu_n(tcu0), .tcd_n(tcd0));

   dstrobe_counter u_stage1 (
      .clk(clk), .rst_n(rst_n), .up_stb(tcu0), .dn_stb(tcd0),
      .clr(clr), .load_n(load_n), .din(din1),
      .q(q1), .tcu_n(tcu1), .tcd_n(tcd1));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_count(input string req);
      chk(req, {q1, q0}, ref8);
   endtask

   task automatic pulse_up(input string req);
      up0 = 1'b0; step(5); up0 = 1'b1; step(8);
      ref8 = (ref8 + 1) % 256;
      chk_count(req);
   endtask

   task automatic pulse_dn(input string req);
      dn0 = 1'b0; step(5); dn0 = 1'b1; step(8);
      ref8 = (ref8 + 255) % 256;
      chk_count(req);
   endtask

   task automatic load8(input int v);
      din0 = v[3:0]; din1 = v[7:4];
      load_n = 1'b0; #1;
      chk("R5 immediate load", {q1, q0}, v);
      step(2);
      load_n = 1'b1; step(4);
      ref8 = v;
      chk("R5 load retained", {q1, q0}, v);
   endtask

   // limit-free terminal outputs must stay high on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (q0 != 4'hF) chk("R6 carry idle", tcu0, 1);
         if (q0 != 4'h0) chk("R7 borrow idle", tcd0, 1);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      chk("R4 reset count", {q1, q0}, 0);
      chk("R7 borrow high with strobe high", tcd0, 1);
      chk("R6 carry high", tcu0, 1);

      pulse_up("R1 up 1");
      pulse_up("R1 up 2");
      pulse_up("R1 up 3");
      for (int i = 0; i < 5; i++) pulse_dn("R2 R3 R11 down through zero");
      chk("R11 8-bit wrap down", {q1, q0}, 254);
      pulse_up("R1 R11 up");
      pulse_up("R3 R11 wrap up to zero");
      chk("R3 wrapped to zero", {q1, q0}, 0);

      // carry follows up strobe at the top count
      load8(8'h0F);
      up0 = 1'b0; step(4);
      chk("R6 carry low at top with up low", tcu0, 0);
      up0 = 1'b1; step(8);
      ref8 = 16;
      chk_count("R11 carry into upper stage");
      chk("R6 carry released", tcu0, 1);

      load8(8'hFE);
      for (int i = 0; i < 3; i++) pulse_up("R3 R11 wrap 8-bit");
      chk("R11 wrap result", {q1, q0}, 1);
      pulse_dn("R2 down to zero");
      dn0 = 1'b0; step(4);
      chk("R7 borrow low at zero with down low", tcd0, 0);
      dn0 = 1'b1; step(8);
      ref8 = 255;
      chk_count("R11 borrow into upper stage");

      // latency
      load8(8'h35);
      up0 = 1'b0; step(4);
      up0 = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R10 no change after edge 1", q0, 5);
      @(posedge clk); @(negedge clk);
      chk("R10 no change after edge 2", q0, 5);
      @(posedge clk); @(negedge clk);
      chk("R10 changed after edge 3", q0, 6);
      step(5);
      ref8 = 8'h36;

      // both strobes low: the down rise is ignored, the later up rise counts
      up0 = 1'b0; dn0 = 1'b0; step(5);
      dn0 = 1'b1; step(8);
      chk_count("R8 down edge with up low ignored");
      up0 = 1'b1; step(8);
      ref8 = 8'h37;
      chk_count("R8 up edge with down high counts");

      // clear overrides load and strobes, same cycle
      din0 = 4'hA; din1 = 4'hA;
      load_n = 1'b0; clr = 1'b1; #1;
      chk("R4 clear beats load", {q1, q0}, 0);
      up0 = 1'b0; step(3); up0 = 1'b1; step(6);
      chk("R4 clear beats strobe", {q1, q0}, 0);
      load_n = 1'b1; clr = 1'b0; step(4);
      ref8 = 0;
      chk_count("R4 zero after clear release");

      // strobe held low across clear recovers
      up0 = 1'b0; step(3);
      clr = 1'b1; step(3); clr = 1'b0; step(3);
      up0 = 1'b1; step(8);
      ref8 = 1;
      chk_count("R9 rise after clear counted");

      // strobe held low across load recovers; load ignores strobes
      dn0 = 1'b0; step(3);
      din0 = 4'h4; din1 = 4'h2; load_n = 1'b0; step(3);
      load_n = 1'b1; step(3);
      chk("R5 load holds despite strobe", {q1, q0}, 8'h24);
      dn0 = 1'b1; step(8);
      ref8 = 8'h23;
      chk_count("R9 rise after load counted");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule